// File: doc/BRIEF.md
# Shared-Latch Wide Register Bridge

This block sits between a processor with a byte-wide data bus and a bank of 16-bit peripheral registers. The processor reaches each wide register through two byte addresses: an even address for the low half and the next odd address for the high half. One 8-bit holding register is shared by every wide register in the bank. The high half of a wide value passes through it, so a full 16-bit read or write happens in a single clock even though the bus moves only one byte per operation.

To write, software first stores the high byte, which only fills the holding register. The following low-byte write then loads the target with the held byte on top and the new byte below, raising a one-cycle load strobe. To read, software first reads the low byte. This returns the low half and, in the same cycle, copies the target's high half into the holding register. The next high-byte read returns that copy. Registers that software alone changes can be marked as direct: their high byte is read straight from the register and their reads leave the holding register alone. A mode input turns direct registers back into latched ones, for when the pair holds a captured value that can change between the two reads.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset the holding register is 0x00, so a high-byte read of a latched register returns 0x00, and no load strobe is raised.
- R2: A write to an odd (high-byte) address inside the map stores the byte in the holding register, raises no load strobe and leaves every target unchanged.
- R3: A write to an even (low-byte) address 2*i raises only load strobe bit i, in the same cycle, with load value {holding register, written byte}.
- R4: A read of an even address returns bits 7:0 of that register combinationally. For a latched register it copies bits 15:8 into the holding register at the clock edge.
- R5: A read of an odd address of a latched register returns the holding register, not the register's current high byte.
- R6: With cap_mode low, a register whose bit in DIRECT_MASK is set returns its own bits 15:8 on a high-byte read. Neither of its reads changes the holding register.
- R7: With cap_mode high, every register is latched, including those marked in DIRECT_MASK.
- R8: The holding register is shared. A high-byte write or low-byte read of any register between the two halves of an access to another register replaces the held byte used by that access.
- R9: Accesses to addresses at or above 2*NUM_REGS return 0x00 on reads, raise no strobe and leave the holding register unchanged.
- R10: When wr_en and rd_en are both high, the write takes effect. The read copy into the holding register is suppressed, while rdata still shows the addressed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Byte address; 2*i is the low half, 2*i+1 the high half of register i |
| wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one cycle per byte write |
| rd_en | input | 1 | Read strobe, one cycle per byte read |
| cap_mode | input | 1 | When high, direct registers are read through the holding register |
| rdata | output | 8 | Read data, valid in the cycle rd_en is high, else 0 |
| ld_en | output | NUM_REGS | Per-register load strobe |
| ld_val | output | 16*NUM_REGS | Load value for register i at bits 16*i+15:16*i |
| reg_val | input | 16*NUM_REGS | Current value of register i at bits 16*i+15:16*i |

## Verification
The holding register has two writers that can meet in one cycle: a high-byte write, which stores bus data, and a low-byte read, which stores a register's high half. A low-byte write reads the holding register in the same cycle that a read could overwrite it. The bench provokes this by raising both strobes on a low-byte address right after a high-byte write. It then judges three things: the load value carries the earlier written byte, rdata shows the old low half, and a later high-byte read still returns the written byte rather than the captured one. A separate interleaving scenario places a foreign access between two halves and expects the corrupted result.

// File: rtl/wide_reg_bridge_pkg.sv
package wide_reg_bridge_pkg;
  typedef logic [7:0]  byte_t;
  typedef logic [15:0] word_t;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = 8;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wbr_rst_sync.sv
module wbr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wbr_addr_decode.sv
module wbr_addr_decode #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned NUM_REGS = 3,
  parameter int unsigned IDX_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              is_hi,
  output logic [IDX_W-1:0]  idx
);
  logic [ADDR_W-2:0] word_addr;

  always_comb begin
    word_addr = addr[ADDR_W-1:1];
    is_hi     = addr[0];
    hit       = (word_addr < (ADDR_W-1)'(NUM_REGS));
    idx       = word_addr[IDX_W-1:0];
  end
endmodule

// File: rtl/wbr_hold_reg.sv
module wbr_hold_reg
  import wide_reg_bridge_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_en,
  input  byte_t set_val,
  output byte_t hold_q
);
  byte_t hold_d;

  always_comb begin
    hold_d = hold_q;
    if (set_en) hold_d = set_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end
endmodule

// File: rtl/wbr_read_mux.sv
module wbr_read_mux
  import wide_reg_bridge_pkg::*;
#(
  parameter int unsigned NUM_REGS = 3,
  parameter int unsigned IDX_W    = 2
) (
  input  logic                     rd_en,
  input  logic                     hit,
  input  logic                     is_hi,
  input  logic                     latched,
  input  logic [IDX_W-1:0]         idx,
  input  byte_t                    hold_q,
  input  logic [16*NUM_REGS-1:0]   reg_val,
  output word_t                    sel_word,
  output byte_t                    rdata
);
  always_comb begin
    sel_word = '0;
    for (int unsigned i = 0; i < NUM_REGS; i++) begin
      if (idx == IDX_W'(i)) sel_word = reg_val[i*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en && hit) begin
      if (!is_hi)       rdata = sel_word[7:0];
      else if (latched) rdata = hold_q;
      else              rdata = sel_word[15:8];
    end
  end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
  import wide_reg_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned NUM_REGS    = 3,
  parameter logic [NUM_REGS-1:0] DIRECT_MASK = 3'b110
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wdata,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic                   cap_mode,
  output logic [7:0]             rdata,
  output logic [NUM_REGS-1:0]    ld_en,
  output logic [16*NUM_REGS-1:0] ld_val,
  input  logic [16*NUM_REGS-1:0] reg_val
);
  localparam int unsigned IDX_W = idx_width(NUM_REGS);

  logic             rst_sync_n;
  logic             hit;
  logic             is_hi;
  logic [IDX_W-1:0] idx;
  logic             latched;
  logic             wr_hi;
  logic             wr_lo;
  logic             rd_cap;
  logic             hold_set;
  byte_t            hold_nxt;
  byte_t            hold_q;
  word_t            sel_word;

  wbr_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_sync_n)
  );

  wbr_addr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dec (
    .addr (addr),
    .hit  (hit),
    .is_hi(is_hi),
    .idx  (idx)
  );

  always_comb begin
    latched  = cap_mode || !DIRECT_MASK[idx];
    wr_hi    = wr_en && hit && is_hi;
    wr_lo    = wr_en && hit && !is_hi;
    rd_cap   = rd_en && !wr_en && hit && !is_hi && latched;
    hold_set = wr_hi || rd_cap;
    hold_nxt = wr_hi ? wdata : sel_word[15:8];
  end

  wbr_hold_reg u_hold (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_en (hold_set),
    .set_val(hold_nxt),
    .hold_q (hold_q)
  );

  wbr_read_mux #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rmux (
    .rd_en   (rd_en),
    .hit     (hit),
    .is_hi   (is_hi),
    .latched (latched),
    .idx     (idx),
    .hold_q  (hold_q),
    .reg_val (reg_val),
    .sel_word(sel_word),
    .rdata   (rdata)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_load
    assign ld_en[i]                   = wr_lo && (idx == IDX_W'(i));
    assign ld_val[i*WORD_W +: WORD_W] = {hold_q, wdata};
  end
endmodule

// File: rtl/wide_reg_bridge_chk.sv
module wide_reg_bridge_chk #(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned NUM_REGS    = 3,
  parameter logic [NUM_REGS-1:0] DIRECT_MASK = 3'b110
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      addr,
  input logic [7:0]             wdata,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic                   cap_mode,
  input logic [7:0]             rdata,
  input logic [NUM_REGS-1:0]    ld_en,
  input logic [16*NUM_REGS-1:0] reg_val,
  input logic [7:0]             hold_q
);
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic             c_hit;
  logic [IDX_W-1:0] c_idx;
  logic             c_latched;
  logic [15:0]      c_word;

  always_comb begin
    c_hit     = (addr[ADDR_W-1:1] < (ADDR_W-1)'(NUM_REGS));
    c_idx     = addr[IDX_W:1];
    c_latched = cap_mode || !DIRECT_MASK[c_idx];
    c_word    = reg_val[c_idx*16 +: 16];
  end

  a_r2_hi_write_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && c_hit && addr[0]) |-> (ld_en == '0));

  a_r2_hi_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && c_hit && addr[0]) |=> (hold_q == $past(wdata)));

  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_en));

  a_r3_lo_write_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && c_hit && !addr[0]) |-> ld_en[c_idx]);

  a_r4_lo_read_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && c_hit && !addr[0] && c_latched) |=> (hold_q == $past(c_word[15:8])));

  a_r6_direct_read_keeps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && c_hit && !c_latched) |=> $stable(hold_q));

  a_r9_outside_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && !c_hit) |-> (ld_en == '0 && rdata == 8'h00));

  a_r9_outside_keeps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && !c_hit) |=> $stable(hold_q));
endmodule

bind wide_reg_bridge wide_reg_bridge_chk #(
  .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .DIRECT_MASK(DIRECT_MASK)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .addr    (addr),
  .wdata   (wdata),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .cap_mode(cap_mode),
  .rdata   (rdata),
  .ld_en   (ld_en),
  .reg_val (reg_val),
  .hold_q  (hold_q)
);

// File: tb/wide_reg_bridge_test.sv
`timescale 1ns/1ps
module wide_reg_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  addr;
  logic [7:0]  wdata;
  logic        wr_en, rd_en, cap_mode;
  logic [7:0]  rdata;
  logic [2:0]  ld_en;
  logic [47:0] ld_val;
  logic [47:0] reg_val;
  logic [15:0] pr [3];

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0]  s_rdata;
  logic [2:0]  s_ld_en;
  logic [47:0] s_ld_val;

  always #2.5 clk = ~clk;

  wide_reg_bridge uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .cap_mode(cap_mode), .rdata(rdata), .ld_en(ld_en),
    .ld_val(ld_val), .reg_val(reg_val)
  );

  // peripheral model: three 16-bit registers loaded by the strobes
  always @(posedge clk) begin
    for (int i = 0; i < 3; i++) if (ld_en[i]) pr[i] <= ld_val[i*16 +: 16];
  end
  assign reg_val = {pr[2], pr[1], pr[0]};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic r, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #1;
    s_rdata = rdata; s_ld_en = ld_en; s_ld_val = ld_val;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 no strobe", {13'd0, ld_en}, 16'h0);
    bus(0, 1, 4'd1, 8'h00);
    check("R1 hold zero", {8'h0, s_rdata}, 16'h0000);
  endtask

  task automatic t_write16;
    bus(1, 0, 4'd1, 8'h12);
    check("R2 no strobe on hi write", {13'd0, s_ld_en}, 16'h0);
    check("R2 target unchanged", pr[0], 16'h0000);
    bus(1, 0, 4'd0, 8'h34);
    check("R3 strobe bit0 only", {13'd0, s_ld_en}, 16'h0001);
    check("R3 load value", s_ld_val[15:0], 16'h1234);
    check("R3 target loaded", pr[0], 16'h1234);
    bus(1, 0, 4'd4, 8'h10);
    check("R3 strobe bit2 only", {13'd0, s_ld_en}, 16'h0004);
    check("R3 reg2 loaded", pr[2], 16'h1210);
  endtask

  task automatic t_read16;
    pr[0] = 16'hABCD;
    bus(0, 1, 4'd0, 8'h00);
    check("R4 low byte", {8'h0, s_rdata}, 16'h00CD);
    pr[0] = 16'h5555;
    bus(0, 1, 4'd1, 8'h00);
    check("R5 hi from hold", {8'h0, s_rdata}, 16'h00AB);
  endtask

  task automatic t_direct;
    pr[1] = 16'h9876;
    bus(0, 1, 4'd3, 8'h00);
    check("R6 direct hi", {8'h0, s_rdata}, 16'h0098);
    bus(0, 1, 4'd2, 8'h00);
    check("R6 direct lo", {8'h0, s_rdata}, 16'h0076);
    bus(0, 1, 4'd1, 8'h00);
    check("R6 hold untouched", {8'h0, s_rdata}, 16'h00AB);
  endtask

  task automatic t_capture;
    cap_mode = 1'b1;
    pr[2] = 16'h4321;
    bus(0, 1, 4'd4, 8'h00);
    check("R7 capture lo", {8'h0, s_rdata}, 16'h0021);
    pr[2] = 16'h0000;
    bus(0, 1, 4'd5, 8'h00);
    check("R7 capture hi from hold", {8'h0, s_rdata}, 16'h0043);
    cap_mode = 1'b0;
  endtask

  task automatic t_interleave;
    bus(1, 0, 4'd1, 8'h11);
    bus(1, 0, 4'd3, 8'h22);
    bus(1, 0, 4'd0, 8'h33);
    check("R8 write corrupted", pr[0], 16'h2233);
    pr[0] = 16'hAA55;
    bus(0, 1, 4'd0, 8'h00);
    bus(1, 0, 4'd5, 8'h77);
    bus(0, 1, 4'd1, 8'h00);
    check("R8 read corrupted", {8'h0, s_rdata}, 16'h0077);
  endtask

  task automatic t_outside;
    bus(1, 0, 4'd1, 8'h5A);
    bus(1, 0, 4'd9, 8'hFF);
    check("R9 no strobe outside", {13'd0, s_ld_en}, 16'h0);
    bus(0, 1, 4'd12, 8'h00);
    check("R9 read zero", {8'h0, s_rdata}, 16'h0000);
    bus(1, 0, 4'd0, 8'h00);
    check("R9 hold kept", pr[0], 16'h5A00);
  endtask

  task automatic t_collide;
    pr[0] = 16'hC3C3;
    bus(1, 0, 4'd1, 8'h66);
    bus(1, 1, 4'd0, 8'h01);
    check("R10 rdata old low", {8'h0, s_rdata}, 16'h00C3);
    check("R10 strobe", {13'd0, s_ld_en}, 16'h0001);
    check("R10 loaded", pr[0], 16'h6601);
    bus(0, 1, 4'd1, 8'h00);
    check("R10 capture suppressed", {8'h0, s_rdata}, 16'h0066);
  endtask

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0; cap_mode = 1'b0;
    for (int i = 0; i < 3; i++) pr[i] = 16'h0000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write16();
    t_read16();
    t_direct();
    t_capture();
    t_interleave();
    t_outside();
    t_collide();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule